// File: doc/BRIEF.md
# Redundant Reference Clock Monitor and Selector

This block supervises three candidate reference clocks, each near 19.44 MHz, from a faster free-running system clock. Each reference is brought into the system domain through a two-flop synchroniser and then edge-detected. Two alarms are kept for each reference. A loss-of-signal alarm measures the gap between successive rising edges. A frequency-offset alarm counts edges over a fixed gate window and compares that count against a programmable acceptance band.

From these alarms the block names one reference as the active one. In manual mode the active index follows an external select value and ignores the alarms. In automatic mode an input counts as eligible only while both of its alarms are clear, and index 0 has the highest priority, then 1, then 2. A policy bit picks between two behaviours. Revertive mode returns to a better input once it has stayed clean for a programmable number of whole windows. Non-revertive mode stays on the current input for as long as it stays healthy.

The downstream clock multiplexer consumes the active index and a flag that reports that no reference is usable.

Top module: `refsel_top`

## Requirements
- R1: After reset the active index is 0, all alarms are clear and the no-reference flag is low; the active index never takes a value above 2.
- R2: In manual mode the active index takes the value of `manualSel` at the next window end, whatever the alarms say; a `manualSel` value of 3 leaves the active index unchanged.
- R3: The loss-of-signal alarm of an input rises once `losLimit` system cycles pass with no synchronised rising edge of that input, and it falls on the first such edge afterwards.
- R4: At every window end, the frequency-offset alarm of an input is set if that window's edge count lies below `expectCount - countTolerance` or above `expectCount + countTolerance`, and cleared otherwise.
- R5: In automatic mode, if the active input is not eligible and some input is eligible, then at the window end the active index moves to the lowest-numbered eligible input.
- R6: In automatic mode with `revertive` low, an eligible active input is kept, even when a lower-numbered input is also eligible.
- R7: In automatic mode with `revertive` high, the active index moves to a lower-numbered eligible input only after that input has been alarm-free for `holdoffWindows` whole gate windows, counting the window that is just ending; after that it moves at the next window end.
- R8: When no input is eligible, the active index holds and `noValidRef` is high, one cycle after the alarm state; `noValidRef` falls one cycle after any input becomes eligible.
- R9: The active index changes only on the system clock edge that closes a gate window, so it changes at most once per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the references |
| rst_n | input | 1 | Active-low synchronous reset |
| refClkIn | input | 3 | Reference clock inputs, asynchronous to clk |
| autoMode | input | 1 | 1 = alarm-driven selection, 0 = manual |
| revertive | input | 1 | Automatic-mode policy: 1 = revertive |
| manualSel | input | 2 | Requested index in manual mode |
| losLimit | input | LOS_W | Edge-free cycles before loss of signal |
| expectCount | input | CNT_W | Nominal edge count per gate window |
| countTolerance | input | CNT_W | Allowed deviation from expectCount |
| holdoffWindows | input | HOLD_W | Clean windows needed before reverting |
| losAlarm | output | 3 | Loss-of-signal alarm per input |
| fosAlarm | output | 3 | Frequency-offset alarm per input |
| activeSel | output | 2 | Index of the active reference |
| noValidRef | output | 1 | High while no input is eligible |

## Verification
The hardest case to reach is the revertive holdoff. The bench has to show that a recovered higher-priority input is held off for a while and then taken back, even though its alarms clear at an edge position that depends on the asynchronous phase of the reference. The stimulus restores input 0 during a long holdoff and then samples twice. The first sample falls well inside the holdoff, where the index must still point at the backup. The second falls well past any possible clear time plus the holdoff, where the index must be 0 again. The bench also sweeps every combination of failed inputs under both policies. For each combination it predicts the set of allowed indices from the policy, and it requires an exact index wherever the policy leaves only one choice.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int REF_COUNT = 3;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic                 windowEnd;
    logic [REF_COUNT-1:0] healthy;
  } refsel_status_t;
endpackage

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
#(
  parameter int GATE_CYCLES = 1024,
  parameter int LOS_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REF_COUNT-1:0] refClkIn,
  input  logic [LOS_W-1:0]     losLimit,
  input  logic [CNT_W-1:0]     expectCount,
  input  logic [CNT_W-1:0]     countTolerance,
  output logic [REF_COUNT-1:0] losAlarm,
  output logic [REF_COUNT-1:0] fosAlarm,
  output refsel_status_t       status
);
  localparam int GATE_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_CYCLES - 1);
  localparam int WIDE_W = CNT_W + 2;

  logic [GATE_W-1:0] gateCnt;
  logic windowEnd;
  logic signed [WIDE_W-1:0] bandLo;
  logic signed [WIDE_W-1:0] bandHi;

  assign windowEnd = (gateCnt == GATE_LAST);
  assign bandLo = $signed({2'b00, expectCount}) - $signed({2'b00, countTolerance});
  assign bandHi = $signed({2'b00, expectCount}) + $signed({2'b00, countTolerance});

  // shared gate window timer
  always_ff @(posedge clk) begin
    if (!rst_n) gateCnt <= '0;
    else if (windowEnd) gateCnt <= '0;
    else gateCnt <= gateCnt + 1'b1;
  end

  for (genvar g = 0; g < REF_COUNT; g++) begin : g_mon
    logic [2:0]              syncPipe;
    logic                    riseSeen;
    logic [LOS_W-1:0]        gapCnt;
    logic [LOS_W:0]          gapNext;
    logic [CNT_W-1:0]        edgeCnt;
    logic [CNT_W:0]          countNow;
    logic signed [WIDE_W-1:0] countWide;
    logic                    outOfBand;
    logic                    losBit;
    logic                    fosBit;

    assign riseSeen  = syncPipe[1] & ~syncPipe[2];
    assign gapNext   = {1'b0, gapCnt} + 1'b1;
    assign countNow  = {1'b0, edgeCnt} + {{CNT_W{1'b0}}, riseSeen};
    assign countWide = $signed({1'b0, countNow});
    assign outOfBand = (countWide < bandLo) || (countWide > bandHi);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syncPipe <= '0;
        gapCnt   <= '0;
        losBit   <= 1'b0;
        edgeCnt  <= '0;
        fosBit   <= 1'b0;
      end else begin
        syncPipe <= {syncPipe[1:0], refClkIn[g]};
        // loss-of-signal gap timer
        if (riseSeen) begin
          gapCnt <= '0;
          losBit <= 1'b0;
        end else begin
          if (gapCnt != '1) gapCnt <= gapNext[LOS_W-1:0];
          if (gapNext >= {1'b0, losLimit}) losBit <= 1'b1;
        end
        // frequency window count
        if (windowEnd) begin
          fosBit  <= outOfBand;
          edgeCnt <= '0;
        end else begin
          edgeCnt <= countNow[CNT_W] ? '1 : countNow[CNT_W-1:0];
        end
      end
    end

    assign losAlarm[g] = losBit;
    assign fosAlarm[g] = fosBit;
  end

  assign status.windowEnd = windowEnd;
  assign status.healthy   = ~losAlarm & ~fosAlarm;
endmodule

// File: rtl/refsel_control.sv
module refsel_control
  import refsel_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  refsel_status_t   status,
  input  logic             autoMode,
  input  logic             revertive,
  input  logic [SEL_W-1:0] manualSel,
  input  logic [HOLD_W-1:0] holdoffWindows,
  output logic [SEL_W-1:0] activeSel,
  output logic             noValidRef
);
  logic [HOLD_W-1:0]    cleanWin  [REF_COUNT];
  logic [HOLD_W-1:0]    cleanNext [REF_COUNT];
  logic [REF_COUNT-1:0] revertReady;
  logic                 anyHealthy;
  logic                 currentHealthy;
  logic                 revertFound;
  logic [SEL_W-1:0]     firstHealthy;
  logic [SEL_W-1:0]     revertPick;
  logic [SEL_W-1:0]     nextSel;

  for (genvar g = 0; g < REF_COUNT; g++) begin : g_clean
    assign cleanNext[g] = !status.healthy[g] ? '0 :
                          ((cleanWin[g] == '1) ? cleanWin[g] : cleanWin[g] + 1'b1);
    assign revertReady[g] = status.healthy[g] && (cleanNext[g] >= holdoffWindows);

    always_ff @(posedge clk) begin
      if (!rst_n) cleanWin[g] <= '0;
      else if (!status.healthy[g]) cleanWin[g] <= '0;
      else if (status.windowEnd) cleanWin[g] <= cleanNext[g];
    end
  end

  always_comb begin
    anyHealthy     = |status.healthy;
    currentHealthy = status.healthy[activeSel];
    firstHealthy   = activeSel;
    revertFound    = 1'b0;
    revertPick     = activeSel;
    for (int i = REF_COUNT - 1; i >= 0; i--) begin
      if (status.healthy[i]) firstHealthy = SEL_W'(i);
      if (revertReady[i] && (SEL_W'(i) < activeSel)) begin
        revertFound = 1'b1;
        revertPick  = SEL_W'(i);
      end
    end

    if (!autoMode)
      nextSel = (manualSel < SEL_W'(REF_COUNT)) ? manualSel : activeSel;
    else if (!anyHealthy)
      nextSel = activeSel;
    else if (!currentHealthy)
      nextSel = firstHealthy;
    else if (revertive && revertFound)
      nextSel = revertPick;
    else
      nextSel = activeSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeSel  <= '0;
      noValidRef <= 1'b0;
    end else begin
      noValidRef <= ~anyHealthy;
      if (status.windowEnd) activeSel <= nextSel;
    end
  end
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int GATE_CYCLES = 1024,
  parameter int LOS_W = 8,
  parameter int CNT_W = 8,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        refClkIn,
  input  logic              autoMode,
  input  logic              revertive,
  input  logic [1:0]        manualSel,
  input  logic [LOS_W-1:0]  losLimit,
  input  logic [CNT_W-1:0]  expectCount,
  input  logic [CNT_W-1:0]  countTolerance,
  input  logic [HOLD_W-1:0] holdoffWindows,
  output logic [2:0]        losAlarm,
  output logic [2:0]        fosAlarm,
  output logic [1:0]        activeSel,
  output logic              noValidRef
);
  refsel_status_t statusBus;

  refsel_datapath #(
    .GATE_CYCLES(GATE_CYCLES),
    .LOS_W(LOS_W),
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk),
    .rst_n(rst_n),
    .refClkIn(refClkIn),
    .losLimit(losLimit),
    .expectCount(expectCount),
    .countTolerance(countTolerance),
    .losAlarm(losAlarm),
    .fosAlarm(fosAlarm),
    .status(statusBus)
  );

  refsel_control #(
    .HOLD_W(HOLD_W)
  ) u_control (
    .clk(clk),
    .rst_n(rst_n),
    .status(statusBus),
    .autoMode(autoMode),
    .revertive(revertive),
    .manualSel(manualSel),
    .holdoffWindows(holdoffWindows),
    .activeSel(activeSel),
    .noValidRef(noValidRef)
  );
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       windowEnd,
  input logic       autoMode,
  input logic       revertive,
  input logic [1:0] manualSel,
  input logic [2:0] losAlarm,
  input logic [2:0] fosAlarm,
  input logic [1:0] activeSel,
  input logic       noValidRef
);
  logic [2:0] healthyNow;
  logic [2:0] healthyPrev;

  assign healthyNow = ~losAlarm & ~fosAlarm;

  always_ff @(posedge clk) begin
    if (!rst_n) healthyPrev <= 3'b111;
    else healthyPrev <= healthyNow;
  end

  assert_active_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    activeSel <= 2'd2);

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (windowEnd && !autoMode && manualSel <= 2'd2) |=> activeSel == $past(manualSel));

  assert_failover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (windowEnd && autoMode && !healthyNow[activeSel] && healthyNow != 3'b000)
      |=> healthyPrev[activeSel]);

  assert_nonrevert_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (windowEnd && autoMode && !revertive && healthyNow[activeSel]) |=> $stable(activeSel));

  assert_revert_upward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (windowEnd && autoMode && revertive && healthyNow[activeSel])
      |=> activeSel <= $past(activeSel));

  assert_hold_when_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (windowEnd && autoMode && healthyNow == 3'b000) |=> $stable(activeSel));

  assert_flag_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    noValidRef == (healthyPrev == 3'b000));

  assert_change_at_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (activeSel != $past(activeSel)) |-> $past(windowEnd));
endmodule

bind refsel_top refsel_checker u_checker (
  .clk(clk),
  .rst_n(rst_n),
  .windowEnd(statusBus.windowEnd),
  .autoMode(autoMode),
  .revertive(revertive),
  .manualSel(manualSel),
  .losAlarm(losAlarm),
  .fosAlarm(fosAlarm),
  .activeSel(activeSel),
  .noValidRef(noValidRef)
);

// File: tb/refsel_top_test.sv
`timescale 1ns/1ps
module refsel_top_test;
  localparam int GATE = 64;
  localparam int LOSW = 8;
  localparam int CNTW = 8;
  localparam int HOLDW = 4;
  localparam real HALF_OK = 25.9;   // ~12.4 edges per window
  localparam real HALF_FAST = 13.7; // ~23 edges
  localparam real HALF_SLOW = 51.3; // ~6 edges, gap ~10 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] refClk = 3'b000;
  logic autoMode, revertive;
  logic [1:0] manualSel;
  logic [LOSW-1:0] losLimit;
  logic [CNTW-1:0] expectCount, countTolerance;
  logic [HOLDW-1:0] holdoffWindows;
  logic [2:0] losAlarm, fosAlarm;
  logic [1:0] activeSel;
  logic noValidRef;

  int checks = 0;
  int failures = 0;
  real halfNs [3];
  int edgeCount = 0;
  int badChanges = 0;
  logic [1:0] lastSel = 2'd0;
  bit monitorOn = 1'b0;
  bit done = 1'b0;

  refsel_top #(.GATE_CYCLES(GATE), .LOS_W(LOSW), .CNT_W(CNTW), .HOLD_W(HOLDW)) uut (
    .clk(clk), .rst_n(rst_n), .refClkIn(refClk), .autoMode(autoMode),
    .revertive(revertive), .manualSel(manualSel), .losLimit(losLimit),
    .expectCount(expectCount), .countTolerance(countTolerance),
    .holdoffWindows(holdoffWindows), .losAlarm(losAlarm), .fosAlarm(fosAlarm),
    .activeSel(activeSel), .noValidRef(noValidRef)
  );

  always #5 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_ref
    initial begin
      #(0.37 + 3.1 * g);
      forever begin
        if (halfNs[g] == 0.0) begin
          refClk[g] = 1'b0;
          #1;
        end else begin
          #(halfNs[g]);
          refClk[g] = ~refClk[g];
        end
      end
    end
  end

  always @(posedge clk) if (rst_n) edgeCount++;

  // R9 monitor: an index change is visible only after an edge closing a window
  always @(negedge clk) begin
    if (monitorOn) begin
      if (activeSel != lastSel && (edgeCount % GATE) != 0) badChanges++;
      lastSel = activeSel;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitWindows(input int n);
    repeat (n * GATE) @(posedge clk);
    @(negedge clk);
  endtask

  // bit i of mask set = input i faulty; input 0 stops, 1 runs fast, 2 runs slow
  task automatic applyMask(input logic [2:0] mask);
    halfNs[0] = mask[0] ? 0.0 : HALF_OK;
    halfNs[1] = mask[1] ? HALF_FAST : HALF_OK;
    halfNs[2] = mask[2] ? HALF_SLOW : HALF_OK;
  endtask

  function automatic int lowestHealthy(input logic [2:0] mask);
    for (int i = 0; i < 3; i++) if (!mask[i]) return i;
    return -1;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] prevMask;
    int prevSel;
    autoMode = 1'b1;
    revertive = 1'b1;
    manualSel = 2'd0;
    losLimit = 8'd20;
    expectCount = 8'd13;
    countTolerance = 8'd2;   // band 11..15
    holdoffWindows = 4'd2;
    applyMask(3'b000);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(activeSel == 2'd0, "R1 reset index", activeSel, 0);
    check(losAlarm == 3'b000, "R1 reset los", losAlarm, 0);
    check(fosAlarm == 3'b000, "R1 reset fos", fosAlarm, 0);
    check(noValidRef == 1'b0, "R1 reset flag", noValidRef, 0);
    lastSel = activeSel;
    monitorOn = 1'b1;
    waitWindows(4);

    // sweep all fault masks under both policies
    prevMask = 3'b000;
    for (int pol = 1; pol >= 0; pol--) begin
      revertive = pol[0];
      for (int m = 0; m < 8; m++) begin
        logic [2:0] mask;
        int low;
        bit allowed;
        mask = 3'(m);
        prevSel = activeSel;
        applyMask(mask);
        waitWindows(8);
        low = lowestHealthy(mask);
        // R3 and R4 alarm expectations
        check(losAlarm == {1'b0, 1'b0, mask[0]}, "R3 los pattern", losAlarm, {2'b00, mask[0]});
        check(fosAlarm == mask, "R4 fos pattern", fosAlarm, mask);
        check(noValidRef == (mask == 3'b111), "R8 flag", noValidRef, mask == 3'b111);
        if (low < 0) begin
          check(activeSel == 2'(prevSel), "R8 hold index", activeSel, prevSel);
        end else if (revertive) begin
          check(activeSel == 2'(low), "R7 revert to lowest eligible", activeSel, low);
        end else if (!mask[prevSel] && !prevMask[prevSel]) begin
          check(activeSel == 2'(prevSel), "R6 stay on healthy", activeSel, prevSel);
        end else begin
          allowed = !mask[activeSel];
          if ($countones(~mask) == 1) allowed = allowed && (activeSel == 2'(low));
          check(allowed, "R5 failover to eligible", activeSel, low);
        end
        prevMask = mask;
      end
    end

    // R3 timing: stop input 0 from a clean state
    revertive = 1'b1;
    applyMask(3'b000);
    waitWindows(8);
    check(activeSel == 2'd0, "R7 settled on input 0", activeSel, 0);
    halfNs[0] = 0.0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(losAlarm[0] == 1'b0, "R3 not before limit", losAlarm[0], 0);
    repeat (22) @(posedge clk);
    @(negedge clk);
    check(losAlarm[0] == 1'b1, "R3 after limit", losAlarm[0], 1);
    halfNs[0] = HALF_OK;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(losAlarm[0] == 1'b0, "R3 clears on edge", losAlarm[0], 0);

    // R7 holdoff: long holdoff delays the return to input 0
    applyMask(3'b000);
    waitWindows(6);
    holdoffWindows = 4'd10;
    halfNs[0] = 0.0;
    waitWindows(4);
    check(activeSel == 2'd1, "R5 failover to input 1", activeSel, 1);
    halfNs[0] = HALF_OK;
    waitWindows(5);
    check(activeSel == 2'd1, "R7 within holdoff", activeSel, 1);
    waitWindows(12);
    check(activeSel == 2'd0, "R7 after holdoff", activeSel, 0);

    // R2 manual mode ignores alarms; value 3 is ignored
    autoMode = 1'b0;
    applyMask(3'b100);
    manualSel = 2'd2;
    waitWindows(3);
    check(activeSel == 2'd2, "R2 manual selects faulty input", activeSel, 2);
    manualSel = 2'd3;
    waitWindows(3);
    check(activeSel == 2'd2, "R2 value 3 ignored", activeSel, 2);
    manualSel = 2'd1;
    waitWindows(2);
    check(activeSel == 2'd1, "R2 manual to input 1", activeSel, 1);

    check(badChanges == 0, "R9 changes only at window end", badChanges, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule